// File: doc/BRIEF.md
# Chainable Unsigned Magnitude Comparator

This block decides how two unsigned words relate and drives one of three relation lines: A above B, A equal to B, or A below B. The word is cut into 4-bit slices. Each slice compares its own nibbles and also accepts a relation from the slice just below it. A slice only uses that incoming relation when its own nibbles are equal.

The slices form a chain. The least significant slice sits at the head of the chain, and the relation lines of the most significant slice are the result. The top module brings out the cascade inputs of the head slice, so a wider comparison can be built by chaining several of these tops. For a stand-alone comparison, tie the equal cascade line high and the other two low.

The logic is purely combinational. It has no clock and no reset. Cascade patterns that are not one-hot follow a fixed resolution rule, given in R7 and R8.

Top module: `mag_cmp_chain`

## Requirements
- R1: With cascade inputs (gt,eq,lt)=(0,1,0), a_in > b_in as unsigned numbers drives a_gt_b=1, a_eq_b=0, a_lt_b=0.
- R2: With cascade inputs (0,1,0), a_in == b_in drives a_gt_b=0, a_eq_b=1, a_lt_b=0.
- R3: With cascade inputs (0,1,0), a_in < b_in drives a_gt_b=0, a_eq_b=0, a_lt_b=1.
- R4: Whenever a_in differs from b_in, the outputs depend only on the operands, and the cascade inputs have no effect on any pattern of them.
- R5: When a_in == b_in and the cascade inputs are one-hot, each output equals its matching cascade input.
- R6: Whenever the cascade inputs are one-hot, exactly one output is high.
- R7: When a_in == b_in and casc_eq_in=1, the result is equal whatever casc_gt_in and casc_lt_in carry.
- R8: When a_in == b_in, casc_eq_in=0 and casc_gt_in equals casc_lt_in, all three outputs are low.
- R9: The word width is 4*SLICES bits. Slice 0 holds bits 3..0 and is the least significant. The highest slice whose nibbles differ decides the result.
- R10: The outputs follow any input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4*SLICES | Operand A, unsigned |
| b_in | input | 4*SLICES | Operand B, unsigned |
| casc_gt_in | input | 1 | Relation "above" from a lower-order stage |
| casc_eq_in | input | 1 | Relation "equal" from a lower-order stage |
| casc_lt_in | input | 1 | Relation "below" from a lower-order stage |
| a_gt_b | output | 1 | A is greater than B |
| a_eq_b | output | 1 | A equals B |
| a_lt_b | output | 1 | A is less than B |

## Verification
Every result is due zero cycles after its stimulus, because no register lies on any path. The bench changes inputs just after a rising edge of its pacing clock and samples the outputs at the following falling edge. This leaves half a period for the combinational paths to settle and keeps sampling clear of the edge that moves the inputs. The 8-bit chain gets every operand pair. The 12-bit chain gets random pairs, biased toward equal upper slices so that the cascade path is exercised.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
    // Three-line relation carried between slices.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    localparam rel_t REL_EQ_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/mag_nibble_cmp.sv
module mag_nibble_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         above,
    output logic         below
);
    // Scan from the top bit down: a bit decides only if all bits above match.
    logic [W:0] match_above;
    logic [W-1:0] win_gt;
    logic [W-1:0] win_lt;

    assign match_above[W] = 1'b1;

    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign win_gt[i]      = match_above[i+1] & a[i] & ~b[i];
        assign win_lt[i]      = match_above[i+1] & ~a[i] & b[i];
        assign match_above[i] = match_above[i+1] & ~(a[i] ^ b[i]);
    end

    assign above = |win_gt;
    assign below = |win_lt;
endmodule

// File: rtl/mag_rel_merge.sv
module mag_rel_merge
    import mag_cmp_pkg::*;
(
    input  logic above,
    input  logic below,
    input  rel_t from_low,
    output rel_t result
);
    always_comb begin
        result = '0;
        if (above) begin
            result.gt = 1'b1;
        end else if (below) begin
            result.lt = 1'b1;
        end else if (from_low.eq) begin
            result.eq = 1'b1;
        end else if (from_low.gt != from_low.lt) begin
            result.gt = from_low.gt;
            result.lt = from_low.lt;
        end
    end
endmodule

// File: rtl/mag_slice.sv
module mag_slice
    import mag_cmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  rel_t               from_low,
    output rel_t               to_high
);
    logic above;
    logic below;

    mag_nibble_cmp #(.W(SLICE_W)) u_nib (
        .a     (a),
        .b     (b),
        .above (above),
        .below (below)
    );

    mag_rel_merge u_merge (
        .above    (above),
        .below    (below),
        .from_low (from_low),
        .result   (to_high)
    );
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int SLICES  = 2,
    parameter int SLICE_W = 4,
    localparam int WORD_W = SLICES * SLICE_W
) (
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic              casc_gt_in,
    input  logic              casc_eq_in,
    input  logic              casc_lt_in,
    output logic              a_gt_b,
    output logic              a_eq_b,
    output logic              a_lt_b
);
    rel_t link [SLICES+1];

    assign link[0] = '{gt: casc_gt_in, eq: casc_eq_in, lt: casc_lt_in};

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        mag_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a        (a_in[s*SLICE_W +: SLICE_W]),
            .b        (b_in[s*SLICE_W +: SLICE_W]),
            .from_low (link[s]),
            .to_high  (link[s+1])
        );
    end

    assign a_gt_b = link[SLICES].gt;
    assign a_eq_b = link[SLICES].eq;
    assign a_lt_b = link[SLICES].lt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
    parameter int WORD_W = 8
) (
    input logic [WORD_W-1:0] a_in,
    input logic [WORD_W-1:0] b_in,
    input logic              casc_gt_in,
    input logic              casc_eq_in,
    input logic              casc_lt_in,
    input logic              a_gt_b,
    input logic              a_eq_b,
    input logic              a_lt_b
);
    always_comb begin
        if (a_in > b_in)
            AST_ABOVE_WINS: assert ({a_gt_b, a_eq_b, a_lt_b} == 3'b100); // R1
        if (a_in < b_in)
            AST_BELOW_WINS: assert ({a_gt_b, a_eq_b, a_lt_b} == 3'b001); // R3
        if (a_in == b_in && casc_eq_in)
            AST_EQ_DOMINATES: assert ({a_gt_b, a_eq_b, a_lt_b} == 3'b010); // R7
        if ($onehot({casc_gt_in, casc_eq_in, casc_lt_in}))
            AST_ONE_HOT_OUT: assert ($onehot({a_gt_b, a_eq_b, a_lt_b})); // R6
        if (a_in == b_in && !casc_eq_in && casc_gt_in == casc_lt_in)
            AST_BAD_CASC_QUIET: assert ({a_gt_b, a_eq_b, a_lt_b} == 3'b000); // R8
    end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WORD_W(WORD_W)) u_chk (
    .a_in       (a_in),
    .b_in       (b_in),
    .casc_gt_in (casc_gt_in),
    .casc_eq_in (casc_eq_in),
    .casc_lt_in (casc_lt_in),
    .a_gt_b     (a_gt_b),
    .a_eq_b     (a_eq_b),
    .a_lt_b     (a_lt_b)
);

// File: tb/mag_cmp_chain_bench.sv
module mag_cmp_chain_bench;
    localparam int W8  = 8;
    localparam int W12 = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W8-1:0]  a8, b8;
    logic [W12-1:0] a12, b12;
    logic g_in, e_in, l_in;
    logic g8, e8, l8, g12, e12, l12;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    mag_cmp_chain #(.SLICES(2)) u_mag_cmp_chain (
        .a_in(a8), .b_in(b8),
        .casc_gt_in(g_in), .casc_eq_in(e_in), .casc_lt_in(l_in),
        .a_gt_b(g8), .a_eq_b(e8), .a_lt_b(l8)
    );

    mag_cmp_chain #(.SLICES(3)) u_mag_cmp_chain_w12 (
        .a_in(a12), .b_in(b12),
        .casc_gt_in(1'b0), .casc_eq_in(1'b1), .casc_lt_in(1'b0),
        .a_gt_b(g12), .a_eq_b(e12), .a_lt_b(l12)
    );

    // Expected {gt,eq,lt} from the requirements.
    function automatic logic [2:0] expect_rel(input logic [W12-1:0] a, input logic [W12-1:0] b,
                                              input logic g, input logic e, input logic l);
        if (a > b) return 3'b100;
        if (a < b) return 3'b001;
        if (e) return 3'b010;
        if (g != l) return {g, 1'b0, l};
        return 3'b000;
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic apply8(input logic [W8-1:0] a, input logic [W8-1:0] b,
                          input logic [2:0] casc, input string req);
        @(posedge clk);
        a8 = a; b8 = b; {g_in, e_in, l_in} = casc;
        @(negedge clk);
        check(req, {g8, e8, l8}, expect_rel({4'h0, a}, {4'h0, b}, casc[2], casc[1], casc[0]));
    endtask

    task automatic apply12(input logic [W12-1:0] a, input logic [W12-1:0] b, input string req);
        @(posedge clk);
        a12 = a; b12 = b;
        @(negedge clk);
        check(req, {g12, e12, l12}, expect_rel(a, b, 1'b0, 1'b1, 1'b0));
    endtask

    // Table: a, b, cascade {gt,eq,lt}
    localparam int NTAB = 12;
    localparam logic [18:0] TAB [NTAB] = '{
        {8'h00, 8'h00, 3'b010},
        {8'hFF, 8'hFF, 3'b010},
        {8'h80, 8'h7F, 3'b010},
        {8'h7F, 8'h80, 3'b010},
        {8'h10, 8'h0F, 3'b010},
        {8'h0F, 8'h10, 3'b010},
        {8'h35, 8'h35, 3'b100},
        {8'h35, 8'h35, 3'b001},
        {8'h36, 8'h35, 3'b001},
        {8'h35, 8'h36, 3'b100},
        {8'hA0, 8'h5F, 3'b001},
        {8'h01, 8'h00, 3'b000}
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        a8 = '0; b8 = '0; a12 = '0; b12 = '0;
        g_in = 1'b0; e_in = 1'b1; l_in = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle/zero inputs: equal (R2, R10)
        @(negedge clk);
        check("R2 idle zero operands", {g8, e8, l8}, 3'b010);
        check("R10 w12 idle", {g12, e12, l12}, 3'b010);

        // Table walk (R1 R3 R4 R5 R9)
        for (int i = 0; i < NTAB; i++)
            apply8(TAB[i][18:11], TAB[i][10:3], TAB[i][2:0], "R9 table R4 R5");

        // Cascade patterns on equal operands (R5 R6 R7 R8)
        for (int p = 0; p < 8; p++) begin
            apply8(8'hC3, 8'hC3, p[2:0], "R7 R8 cascade pattern");
            if ($onehot(p[2:0]))
                check("R6 one-hot out", {g8, e8, l8}, p[2:0]);
        end

        // Differing operands ignore every cascade pattern (R4)
        for (int p = 0; p < 8; p++) begin
            apply8(8'h4A, 8'h4B, p[2:0], "R4 cascade ignored below");
            apply8(8'hB4, 8'hA4, p[2:0], "R4 cascade ignored above");
        end

        // Exhaustive 8-bit with seed cascade (R1 R2 R3)
        for (int i = 0; i < 65536; i++)
            apply8(i[15:8], i[7:0], 3'b010, "R1 R2 R3 exhaustive");

        // Random 12-bit, biased to shared upper slices (R9)
        for (int i = 0; i < 3000; i++) begin
            logic [W12-1:0] ra, rb;
            ra = W12'($urandom);
            rb = W12'($urandom);
            case (i % 4)
                1: rb = {ra[11:4], rb[3:0]};
                2: rb = {ra[11:8], rb[7:0]};
                3: rb = ra;
                default: ;
            endcase
            apply12(ra, rb, "R9 w12 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule